// File: doc/BRIEF.md
# Relative Branch Resolver with Page-Crossing Penalty

This block settles a conditional relative branch for an 8-bit accumulator-style processor core. One cycle after a request is presented, it reports whether the branch is taken, the program counter execution continues from, and how many extra cycles the timing logic must stall.

Each request carries the following inputs:
- a 3-bit condition select;
- the four status flags: negative, overflow, carry and zero;
- the address of the instruction that follows the branch;
- the 8-bit displacement byte.

When the condition holds, the displacement is read as a signed two's-complement value and added to the follow-on address. Address arithmetic wraps within the 16-bit space.

The stall count depends on the outcome. A branch that is not taken costs nothing extra. A taken branch costs one extra cycle when the target stays inside the same 256-byte page. It costs two extra cycles when the upper address byte changes.

Fetching the displacement byte and keeping the core's overall cycle count are handled elsewhere. The results are registered and stay unchanged until the next request is accepted.

Top module: `relbr_unit`

## Requirements
- R1: `cond_sel` picks the tested flag and its required value. The flag is chosen by bits [2:1]: 0 is N, 1 is V, 2 is C and 3 is Z. Bit [0] is the value the flag must have for the branch to be taken. So 0 means N clear, 1 means N set, 2 means V clear, 3 means V set, 4 means C clear, 5 means C set, 6 means Z clear and 7 means Z set.
- R2: For a taken branch, `pc_out` equals `pc_next` plus the sign-extended `disp`.
- R3: For a branch that is not taken, `pc_out` equals `pc_next` and `extra_cycles` is 0.
- R4: For a taken branch whose target has the same bits [15:8] as `pc_next`, `extra_cycles` is 1.
- R5: For a taken branch whose target differs from `pc_next` in bits [15:8], `extra_cycles` is 2.
- R6: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R7: In a cycle with `in_valid` low, `pc_out`, `taken` and `extra_cycles` do not change.
- R8: After synchronous reset, `out_valid`, `taken`, `extra_cycles` and `pc_out` are all 0.
- R9: Target arithmetic wraps modulo 65536 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cond_sel | input | 3 | Branch condition select |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc_next | input | 16 | Address following the branch instruction |
| disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result strobe, one cycle after request |
| pc_out | output | 16 | Resolved program counter |
| taken | output | 1 | Branch condition held |
| extra_cycles | output | 2 | Stall count: 0, 1 or 2 |

## Verification
Every condition select is tried against all sixteen flag combinations. This separates a wrong flag choice from a wrong polarity, and confirms that a branch which is not taken leaves the address alone.

Every displacement value is then applied, with a condition that is always taken, from follow-on addresses placed at the following points:
- the start of a page;
- the end of a page;
- the middle of a page;
- the two ends of the address space.

These patterns separate same-page targets from crossings in both directions, and they expose sign-extension errors and wrap-around errors at 0x0000 and 0xFFFF.

Idle cycles between requests confirm that the outputs hold.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

    typedef enum logic [2:0] {
        BR_N_CLR = 3'd0,
        BR_N_SET = 3'd1,
        BR_V_CLR = 3'd2,
        BR_V_SET = 3'd3,
        BR_C_CLR = 3'd4,
        BR_C_SET = 3'd5,
        BR_Z_CLR = 3'd6,
        BR_Z_SET = 3'd7
    } br_cond_e;

    typedef enum logic [1:0] {
        PEN_NONE  = 2'd0,
        PEN_SAME  = 2'd1,
        PEN_CROSS = 2'd2
    } br_pen_e;

    typedef struct packed {
        logic n;
        logic v;
        logic c;
        logic z;
    } br_flags_t;

    // Selected flag compared with the polarity carried in bit 0 of the select.
    function automatic logic br_cond_true(br_cond_e sel, br_flags_t f);
        logic picked;
        unique case (sel[2:1])
            2'd0:    picked = f.n;
            2'd1:    picked = f.v;
            2'd2:    picked = f.c;
            default: picked = f.z;
        endcase
        return picked == sel[0];
    endfunction

endpackage

// File: rtl/relbr_cond.sv
module relbr_cond
    import relbr_pkg::*;
(
    input  logic [2:0] sel,
    input  br_flags_t  flags,
    output logic       met
);
    always_comb met = br_cond_true(br_cond_e'(sel), flags);
endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int PAGE_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target,
    output logic              crossed
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ext_off;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        ext_off = {{EXT_W{offset[OFF_W-1]}}, offset};
        target  = base + ext_off;
        diff    = base ^ target;
        crossed = |diff[ADDR_W-1:PAGE_W];
    end
endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
    import relbr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        cond_sel,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [OFF_W-1:0]  disp,
    output logic              out_valid,
    output logic [ADDR_W-1:0] pc_out,
    output logic              taken,
    output logic [1:0]        extra_cycles
);
    br_flags_t         flags;
    logic              met;
    logic [ADDR_W-1:0] tgt;
    logic              crossed;
    br_pen_e           pen;

    assign flags = '{n: flag_n, v: flag_v, c: flag_c, z: flag_z};

    relbr_cond u_cond (
        .sel   (cond_sel),
        .flags (flags),
        .met   (met)
    );

    relbr_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .PAGE_W (PAGE_W)
    ) u_tgt (
        .base    (pc_next),
        .offset  (disp),
        .target  (tgt),
        .crossed (crossed)
    );

    always_comb begin
        if (!met)        pen = PEN_NONE;
        else if (crossed) pen = PEN_CROSS;
        else             pen = PEN_SAME;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            pc_out       <= '0;
            taken        <= 1'b0;
            extra_cycles <= PEN_NONE;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                taken        <= met;
                pc_out       <= met ? tgt : pc_next;
                extra_cycles <= pen;
            end
        end
    end

    // R6: result strobe follows a request by one cycle
    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R7: outputs hold without a request
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pc_out) && $stable(taken) && $stable(extra_cycles)));
    // R3: branch not taken keeps the address and costs nothing
    a_r3_not_taken: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !taken) |-> (extra_cycles == 2'd0 && pc_out == $past(pc_next)));
    // R4: taken within the page costs one cycle
    a_r4_same_page: assert property (@(posedge clk) disable iff (rst)
        (out_valid && taken && pc_out[ADDR_W-1:PAGE_W] == $past(pc_next[ADDR_W-1:PAGE_W]))
        |-> extra_cycles == 2'd1);
    // R5: taken across a page costs two cycles
    a_r5_cross: assert property (@(posedge clk) disable iff (rst)
        (out_valid && taken && pc_out[ADDR_W-1:PAGE_W] != $past(pc_next[ADDR_W-1:PAGE_W]))
        |-> extra_cycles == 2'd2);
endmodule

// File: tb/sim_relbr_unit.sv
`timescale 1ns/1ps
module sim_relbr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        flag_n = 0, flag_v = 0, flag_c = 0, flag_z = 0;
    logic [15:0] pc_next = '0;
    logic [7:0]  disp = '0;
    logic        out_valid;
    logic [15:0] pc_out;
    logic        taken;
    logic [1:0]  extra_cycles;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    relbr_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z),
        .pc_next(pc_next), .disp(disp), .out_valid(out_valid),
        .pc_out(pc_out), .taken(taken), .extra_cycles(extra_cycles)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one request and check the registered result (R1..R6, R9), then
    // one idle cycle (R6 low strobe, R7 hold).
    task automatic run_one(int c, int flg, int pc, int d);
        int fl, want_t, so, tg, want_pc, want_x;
        cond_sel = 3'(c);
        {flag_n, flag_v, flag_c, flag_z} = 4'(flg);
        pc_next  = 16'(pc);
        disp     = 8'(d);
        in_valid = 1'b1;
        case (c / 2)
            0: fl = (flg >> 3) & 1;
            1: fl = (flg >> 2) & 1;
            2: fl = (flg >> 1) & 1;
            default: fl = flg & 1;
        endcase
        want_t  = (fl == (c % 2)) ? 1 : 0;
        so      = (d >= 128) ? d - 256 : d;
        tg      = (pc + so) & 65535;
        want_pc = want_t ? tg : pc;
        want_x  = !want_t ? 0 : (((tg >> 8) != (pc >> 8)) ? 2 : 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 out_valid", int'(out_valid), 1);
        chk("R1 taken", int'(taken), want_t);
        if (want_t) chk("R2/R9 target", int'(pc_out), want_pc);
        else        chk("R3 pc kept", int'(pc_out), want_pc);
        if (!want_t)          chk("R3 no penalty", int'(extra_cycles), 0);
        else if (want_x == 1) chk("R4 same page", int'(extra_cycles), 1);
        else                  chk("R5 page cross", int'(extra_cycles), 2);
        pc_next  = ~pc_next;
        disp     = ~disp;
        cond_sel = ~cond_sel;
        @(negedge clk);
        chk("R6 idle strobe", int'(out_valid), 0);
        chk("R7 hold pc", int'(pc_out), want_pc);
        chk("R7 hold penalty", int'(extra_cycles), want_x);
    endtask

    initial begin
        int pcs[6];
        pcs = '{16'h0000, 16'h00FF, 16'h1280, 16'h12FF, 16'hFFF0, 16'h8000};
        repeat (3) @(negedge clk);
        chk("R8 out_valid", int'(out_valid), 0);
        chk("R8 taken", int'(taken), 0);
        chk("R8 penalty", int'(extra_cycles), 0);
        chk("R8 pc_out", int'(pc_out), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1/R3: every condition against every flag pattern
        for (int c = 0; c < 8; c++)
            for (int f = 0; f < 16; f++)
                run_one(c, f, 16'h4410 + c * 16 + f, 8'h05);
        // R2/R4/R5/R9: every displacement, always-taken condition (N clear)
        for (int p = 0; p < 6; p++)
            for (int d = 0; d < 256; d++)
                run_one(0, 0, pcs[p], d);
        done = 1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
        end
    end

    initial begin
        wait (done || $time > 20000 * 8);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule